// File: doc/BRIEF.md
# Atomic-Write Interrupt Controller

This block collects up to fifteen interrupt source lines into one 32-bit control and status word on a memory-mapped bus and drives a single interrupt request to the CPU. Any cycle in which a source line is high latches that line's pending flag. The flag stays set until software acknowledges it. A per-line enable mask and a global enable decide whether pending lines reach the CPU.

Software never has to read, modify and write the word back. A single store can change the global enable, the per-line enables and the acknowledgements. The global enable bit in the written word has two roles. It becomes the new global enable. It also selects whether the ones in the enable field set or clear their lines, and enable bits written as zero keep their value. Acknowledgement works the same way: a one in a pending position clears that flag, and a zero leaves it alone.

The number of lines in use is a parameter. The fields in the word stay at fixed positions for any line count, and positions of lines that are not in use read as zero.

Top module: `atomic_pic`

## Requirements
- R1: After reset the global enable, every enable bit and every pending flag are 0, so a read returns 0x00000000 and `irq_o` is low.
- R2: A cycle in which source line i is high sets pending flag i (bit i of the word). The flag stays set after the line falls.
- R3: A write with bit i (i < 15) set clears pending flag i. Pending bits written as 0 are unchanged.
- R4: If source line i is high in the same cycle as a write that acknowledges flag i, the flag stays set.
- R5: Every write loads the global enable (bit 31) from bit 31 of the written word.
- R6: In a write with bit 31 = 1, each 1 in bits 30..16 sets the enable for line (bit − 16). Enable bits written as 0 keep their previous value.
- R7: In a write with bit 31 = 0, each 1 in bits 30..16 clears the matching enable. Enable bits written as 0 keep their value, so writing 0x7FFF0000 disables every line.
- R8: Bit 15 reads 1 exactly when some line is both enabled and pending. Writing bit 15 has no effect on any state.
- R9: `irq_o` is high exactly when the global enable is 1 and bit 15 would read 1. It reflects the state registered at the latest clock edge.
- R10: A read strobed in one cycle presents {global enable, enables[14:0], any, pending[14:0]} on `rd_data_o` after that clock edge. The word shows the state before the edge. Field bits of lines at or above NUM_LINES read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_LINES | Interrupt source lines, active high |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Word written |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Read word, valid the cycle after the strobe |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The hardest case to bring about is the one where a source line and the acknowledge of that same line land on one clock edge, so that setting has to win over clearing. The stimulus first lets a line go pending. It then holds that line high in the very cycle it writes the acknowledge, and reads the word back afterwards. The enable update is swept exhaustively on a four-line instance: every starting mask, every written mask and both values of the global bit. The ANY flag and the interrupt output are swept over all pairs of enable and pending masks.

// File: rtl/atomic_pic_pkg.sv
package atomic_pic_pkg;
   localparam int WORD_W    = 32;
   localparam int MAX_LINES = 15;
   localparam int GIE_BIT   = 31;
   localparam int EN_LSB    = 16;
   localparam int ANY_BIT   = 15;
   localparam int PEND_LSB  = 0;

   function automatic logic [WORD_W-1:0] pack_word(
      input logic                 gie,
      input logic [MAX_LINES-1:0] en,
      input logic                 any,
      input logic [MAX_LINES-1:0] pend);
      return {gie, en, any, pend};
   endfunction
endpackage

// File: rtl/atomic_pic_wdec.sv
module atomic_pic_wdec
   import atomic_pic_pkg::*;
#(
   parameter int NUM_LINES = 15
) (
   input  logic                  wr_en_i,
   input  logic [WORD_W-1:0]     wr_data_i,
   output logic                  gie_load_o,
   output logic                  gie_val_o,
   output logic [NUM_LINES-1:0]  en_set_o,
   output logic [NUM_LINES-1:0]  en_clr_o,
   output logic [NUM_LINES-1:0]  ack_o
);
   logic [NUM_LINES-1:0] field_en;
   logic                 unused_word_bits;

   assign field_en   = wr_data_i[EN_LSB +: NUM_LINES];
   assign gie_load_o = wr_en_i;
   assign gie_val_o  = wr_data_i[GIE_BIT];

   always_comb begin
      en_set_o = '0;
      en_clr_o = '0;
      ack_o    = '0;
      if (wr_en_i) begin
         ack_o = wr_data_i[PEND_LSB +: NUM_LINES];
         if (wr_data_i[GIE_BIT]) en_set_o = field_en;
         else                    en_clr_o = field_en;
      end
   end

   // bit 15 and field bits of absent lines carry no meaning on write
   assign unused_word_bits = &{1'b0, wr_data_i};
endmodule

// File: rtl/atomic_pic_cell.sv
module atomic_pic_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic src_i,
   input  logic ack_i,
   input  logic en_set_i,
   input  logic en_clr_i,
   output logic pend_o,
   output logic en_o,
   output logic hit_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_o <= 1'b0;
      else if (src_i)  pend_o <= 1'b1;
      else if (ack_i)  pend_o <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_o <= 1'b0;
      else if (en_set_i)  en_o <= 1'b1;
      else if (en_clr_i)  en_o <= 1'b0;
   end

   assign hit_o = pend_o & en_o;
endmodule

// File: rtl/atomic_pic.sv
module atomic_pic
   import atomic_pic_pkg::*;
#(
   parameter int NUM_LINES = 15
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] src_i,
   input  logic                 wr_en_i,
   input  logic [31:0]          wr_data_i,
   input  logic                 rd_en_i,
   output logic [31:0]          rd_data_o,
   output logic                 irq_o
);
   if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
      $error("atomic_pic: NUM_LINES must lie in 1..15");
   end

   logic                 gie_load, gie_val, gie_q;
   logic [NUM_LINES-1:0] en_set, en_clr, ack;
   logic [NUM_LINES-1:0] en_q, act_q, hit;
   logic                 any_hit;
   logic [MAX_LINES-1:0] en_word, act_word;

   atomic_pic_wdec #(.NUM_LINES(NUM_LINES)) u_wdec (
      .wr_en_i    (wr_en_i),
      .wr_data_i  (wr_data_i),
      .gie_load_o (gie_load),
      .gie_val_o  (gie_val),
      .en_set_o   (en_set),
      .en_clr_o   (en_clr),
      .ack_o      (ack)
   );

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      atomic_pic_cell u_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .src_i    (src_i[i]),
         .ack_i    (ack[i]),
         .en_set_i (en_set[i]),
         .en_clr_i (en_clr[i]),
         .pend_o   (act_q[i]),
         .en_o     (en_q[i]),
         .hit_o    (hit[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gie_q <= 1'b0;
      else if (gie_load) gie_q <= gie_val;
   end

   assign any_hit = |hit;
   assign irq_o   = gie_q & any_hit;

   if (NUM_LINES == MAX_LINES) begin : g_full
      assign en_word  = en_q;
      assign act_word = act_q;
   end else begin : g_padded
      assign en_word  = {{(MAX_LINES-NUM_LINES){1'b0}}, en_q};
      assign act_word = {{(MAX_LINES-NUM_LINES){1'b0}}, act_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_data_o <= '0;
      else if (rd_en_i) rd_data_o <= pack_word(gie_q, en_word, any_hit, act_word);
   end
endmodule

// File: rtl/atomic_pic_chk.sv
module atomic_pic_chk #(
   parameter int NUM_LINES = 15
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] src_i,
   input logic                 wr_en_i,
   input logic [31:0]          wr_data_i,
   input logic                 rd_en_i,
   input logic [31:0]          rd_data_o,
   input logic                 irq_o,
   input logic                 gie_q,
   input logic [NUM_LINES-1:0] en_q,
   input logic [NUM_LINES-1:0] act_q
);
   assert_src_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (src_i != '0) |=> ((act_q & $past(src_i)) == $past(src_i)));

   assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> ((act_q & $past(wr_data_i[NUM_LINES-1:0] & ~src_i)) == '0));

   assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && ((src_i & wr_data_i[NUM_LINES-1:0]) != '0))
      |=> ((act_q & $past(src_i)) == $past(src_i)));

   assert_gie_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (gie_q == $past(wr_data_i[31])));

   assert_enable_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_data_i[31])
      |=> (((en_q & $past(wr_data_i[16 +: NUM_LINES])) == $past(wr_data_i[16 +: NUM_LINES]))
           && (($past(en_q) & ~en_q) == '0)));

   assert_enable_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !wr_data_i[31])
      |=> (((en_q & $past(wr_data_i[16 +: NUM_LINES])) == '0)
           && ((en_q & ~$past(en_q)) == '0)));

   assert_any_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_i |=> (rd_data_o[15] == ($past(en_q & act_q) != '0)));

   assert_irq_needs_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (gie_q && ((en_q & act_q) != '0)));

   assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !gie_q |-> !irq_o);

   assert_read_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en_i |=> ((rd_data_o[31] == $past(gie_q))
                   && (rd_data_o[14:0] == 15'($past(act_q)))
                   && (rd_data_o[30:16] == 15'($past(en_q)))));
endmodule

bind atomic_pic atomic_pic_chk #(.NUM_LINES(NUM_LINES)) u_atomic_pic_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_i     (src_i),
   .wr_en_i   (wr_en_i),
   .wr_data_i (wr_data_i),
   .rd_en_i   (rd_en_i),
   .rd_data_o (rd_data_o),
   .irq_o     (irq_o),
   .gie_q     (gie_q),
   .en_q      (en_q),
   .act_q     (act_q)
);

// File: tb/atomic_pic_bench.sv
`timescale 1ns/1ps
module atomic_pic_bench;
   localparam int NL = 4;
   localparam logic [NL-1:0] ALL = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] src_i = '0;
   logic          wr_en_i = 1'b0;
   logic [31:0]   wr_data_i = '0;
   logic          rd_en_i = 1'b0;
   logic [31:0]   rd_data_o;
   logic          irq_o;

   int checks = 0;
   int fails  = 0;

   logic          m_gie = 1'b0;
   logic [NL-1:0] m_en  = '0;
   logic [NL-1:0] m_act = '0;

   always #2 clk = ~clk;

   atomic_pic #(.NUM_LINES(NL)) u_atomic_pic (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en_i(wr_en_i),
      .wr_data_i(wr_data_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
   );

   function automatic logic [31:0] model_word();
      logic [14:0] e15, a15;
      e15 = 15'(m_en);
      a15 = 15'(m_act);
      return {m_gie, e15, |(m_en & m_act), a15};
   endfunction

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic [NL-1:0] s, input logic w, input logic [31:0] d,
                      input logic r, input string tag);
      logic [31:0] exp_rd;
      logic [NL-1:0] e_field;
      @(negedge clk);
      src_i = s; wr_en_i = w; wr_data_i = d; rd_en_i = r;
      exp_rd = model_word();
      @(posedge clk);
      m_act = (m_act & ~(w ? d[NL-1:0] : '0)) | s;
      if (w) begin
         e_field = d[16 +: NL];
         m_gie = d[31];
         if (d[31]) m_en = m_en | e_field;
         else       m_en = m_en & ~e_field;
      end
      #1;
      src_i = '0; wr_en_i = 1'b0; wr_data_i = '0; rd_en_i = 1'b0;
      if (r) chk(rd_data_o, exp_rd, tag);
      chk({31'd0, irq_o}, {31'd0, m_gie & |(m_en & m_act)}, "R9 irq");
   endtask

   task automatic rd(input string tag);
      cyc('0, 1'b0, 32'h0, 1'b1, tag);
   endtask

   task automatic wipe();
      cyc('0, 1'b1, 32'h7FFF_7FFF, 1'b0, "wipe");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      chk({31'd0, irq_o}, 32'd0, "R1 irq");
      rd("R1");

      // R2: latch and hold
      for (int i = 0; i < NL; i++) begin
         cyc(NL'(1 << i), 1'b0, 32'h0, 1'b0, "R2");
         rd("R2");
         rd("R2 held");
         wipe();
      end

      // R3: every acknowledge pattern
      for (int p = 0; p < 16; p++) begin
         cyc(ALL, 1'b0, 32'h0, 1'b0, "R3");
         cyc('0, 1'b1, 32'(p) | 32'h0000_7FF0, 1'b1, "R3");
         rd("R3");
         wipe();
      end

      // R4: set beats clear on the same edge
      for (int i = 0; i < NL; i++) begin
         cyc(ALL, 1'b0, 32'h0, 1'b0, "R4");
         cyc(NL'(1 << i), 1'b1, 32'h0000_7FFF, 1'b0, "R4");
         rd("R4");
         wipe();
      end

      // R5: global enable follows bit 31 alone
      cyc('0, 1'b1, 32'h8000_0000, 1'b0, "R5");
      rd("R5");
      cyc('0, 1'b1, 32'h0000_0000, 1'b0, "R5");
      rd("R5");

      // R6 / R7: exhaustive enable update sweep
      for (int g = 0; g < 2; g++)
         for (int st = 0; st < 16; st++)
            for (int mk = 0; mk < 16; mk++) begin
               cyc('0, 1'b1, 32'h7FFF_0000, 1'b0, "R7");
               cyc('0, 1'b1, 32'h8000_0000 | (32'(st) << 16), 1'b0, "R6");
               cyc('0, 1'b1, (32'(g) << 31) | (32'(mk) << 16), 1'b0, g ? "R6" : "R7");
               rd(g ? "R6" : "R7");
            end
      cyc('0, 1'b1, 32'hFFFF_0000, 1'b0, "R7");
      cyc('0, 1'b1, 32'h7FFF_0000, 1'b0, "R7");
      rd("R7 all off");

      // R8 / R9: all enable x pending pairs, bit 15 writes ignored
      for (int e = 0; e < 16; e++)
         for (int a = 0; a < 16; a++) begin
            wipe();
            cyc('0, 1'b1, 32'h8000_0000 | (32'(e) << 16), 1'b0, "R9");
            cyc(NL'(a), 1'b0, 32'h0, 1'b0, "R9");
            cyc('0, 1'b1, 32'h8000_8000, 1'b1, "R8");
            rd("R8 bit15 write");
            cyc('0, 1'b1, 32'h0000_8000, 1'b0, "R9 gie off");
            rd("R9");
         end

      // R10: unused line positions read zero
      wipe();
      cyc(ALL, 1'b1, 32'hFFFF_0000, 1'b0, "R10");
      rd("R10");
      chk(rd_data_o & 32'h7FF0_7FF0, 32'h0, "R10 unused bits");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule